// File: doc/BRIEF.md
# DDR Read Burst Data Sequencer

This block is the device-side read path of a double-data-rate synchronous DRAM, modelled at single clock rate. Each clock carries two data words: one for the rising half and one for the falling half. A READ command names a bank, a starting column and an auto-precharge flag. The sequencer holds the command for the selected CAS latency and drives the strobe low for one clock as a preamble. It then streams the burst two elements per clock from an internal array, and drives the strobe high in the rising half and low in the falling half of every data clock.

A READ may arrive on any clock, including while an earlier burst is still in flight. A READ issued before the earlier burst has finished cuts that burst short. A READ issued exactly at its end chains onto it. In both cases the new data follows the old with no idle half-cycle and no preamble in between. A burst that runs to full length with auto-precharge set raises a one-clock precharge request for its bank. CAS latency and burst length are taken from the configuration pins only while nothing is in flight.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released with no command, dq_oe_o, dqs_oe_o, pre_req_o, dqs_o, dq_rise_o and dq_fall_o are all zero.
- R2: For a READ sampled in clock cycle c, the first data pair is driven in cycle c+CL, where CL is 3 when cas3_i=1 and 2 when cas3_i=0. The remaining pairs follow in consecutive cycles, BL/2 pairs in all.
- R3: The word at bank b and column k is {0000, ~a, a} with a = b*16 + k (6 bits). dq_rise_o carries the element with the even burst offset and dq_fall_o the element with the following offset.
- R4: Burst element n (n = 0 .. BL-1) reads column (col & ~(BL-1)) | ((col + n) & (BL-1)). BL is 2 for bl_sel_i=00, 4 for 01, and 8 for 10 or 11.
- R5: In every data cycle dqs_o = 2'b10 (high in the rising half, low in the falling half, so the last element carries the low postamble). Whenever dqs_oe_o is low, dqs_o and both data words are zero.
- R6: A burst whose first pair is not directly preceded by a data cycle gets exactly one preamble cycle before it, with dqs_oe_o=1, dq_oe_o=0 and dqs_o=2'b00.
- R7: In the cycle after the last pair, with no further burst due, dq_oe_o and dqs_oe_o are both low.
- R8: A READ issued x cycles after a previous one, with x < BL/2, cuts the previous burst to x pairs, and the new burst's first pair follows in the next cycle.
- R9: A READ issued exactly BL/2 cycles after the previous one chains its data onto the end of the previous burst, with no gap and no preamble.
- R10: A READ issued one cycle later than a chaining READ puts its preamble directly after the previous last pair. A READ issued later still leaves at least one cycle with both drive-enables low.
- R11: pre_req_o is high, with pre_bank_o set to the burst's bank, in exactly the cycle of the last pair of a burst that ran to full length with auto-precharge set. It is never raised for a burst that was cut short.
- R12: cas3_i and bl_sel_i are taken only in cycles where no command is pending and no burst is running. A READ accepted while busy uses the latency and length already in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | READ command strobe for this cycle |
| rd_bank_i | input | BA_W | Bank address of the READ |
| rd_col_i | input | COL_W | Starting column of the READ |
| rd_ap_i | input | 1 | Auto-precharge request for the READ |
| cas3_i | input | 1 | CAS latency select: 1 gives 3 clocks, 0 gives 2 |
| bl_sel_i | input | 2 | Burst length select: 00 gives 2, 01 gives 4, other values give 8 |
| dq_rise_o | output | DQ_W | Data word for the rising half of the clock |
| dq_fall_o | output | DQ_W | Data word for the falling half of the clock |
| dq_oe_o | output | 1 | Data drive-enable |
| dqs_o | output | 2 | Strobe level, {rising half, falling half} |
| dqs_oe_o | output | 1 | Strobe drive-enable |
| pre_req_o | output | 1 | One-cycle precharge request |
| pre_bank_o | output | BA_W | Bank to precharge |

## Verification
The bench aims at overlapping commands. It cuts a burst short, chains two bursts exactly at the boundary, streams length-two bursts every clock, and issues READs one and two cycles past the chaining point. A design that scheduled by arrival order alone would show a hole or a stray preamble in the data stream. A design that waited for the running burst would drop the cut-short data or shift the second burst late. Wrapping starting columns expose a sequencer that counts linearly across the aligned block. An auto-precharge burst that is cut short shows whether a design raises a request for a row still in use. A configuration change made mid-traffic would, if picked up early, change the length of a burst already accepted.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  parameter int unsigned BA_W   = 2;
  parameter int unsigned COL_W  = 4;
  parameter int unsigned DQ_W   = 16;
  parameter int unsigned CL_MAX = 3;
  parameter int unsigned MAX_BL = 8;

  localparam int unsigned AW     = BA_W + COL_W;
  localparam int unsigned PAIR_W = $clog2(MAX_BL / 2);
  localparam int unsigned PIPE_D = CL_MAX - 1;

  typedef struct packed {
    logic             vld;
    logic [BA_W-1:0]  bank;
    logic [COL_W-1:0] col;
    logic             ap;
  } rd_cmd_t;

  // index of the final pair for a burst-length select code
  function automatic logic [PAIR_W-1:0] last_pair(input logic [1:0] sel);
    case (sel)
      2'b00:   return '0;
      2'b01:   return PAIR_W'(1);
      default: return PAIR_W'(MAX_BL / 2 - 1);
    endcase
  endfunction

  function automatic logic [DQ_W-1:0] cell_word(input logic [BA_W-1:0] bank,
                                                 input logic [COL_W-1:0] col);
    logic [AW-1:0] a;
    a = {bank, col};
    return DQ_W'({~a, a});
  endfunction
endpackage

// File: rtl/ddr_rd_cmd_pipe.sv
module ddr_rd_cmd_pipe
  import ddr_rd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rd_cmd_t cmd_i,
  input  logic    cl3_i,
  output rd_cmd_t tap_o,
  output logic    busy_o
);
  rd_cmd_t stage_q [PIPE_D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PIPE_D; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= cmd_i;
      for (int i = 1; i < PIPE_D; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // stage k holds a command k+1 cycles old; launch one cycle before data
  assign tap_o = cl3_i ? stage_q[PIPE_D-1] : stage_q[0];

  always_comb begin
    busy_o = 1'b0;
    for (int i = 0; i < PIPE_D; i++) busy_o = busy_o | stage_q[i].vld;
  end
endmodule

// File: rtl/ddr_rd_burst_eng.sv
module ddr_rd_burst_eng
  import ddr_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  rd_cmd_t           cmd_i,
  input  logic [PAIR_W-1:0] lim_i,
  output logic              act_o,
  output logic              last_o,
  output logic              ap_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [COL_W-1:0]  col_r_o,
  output logic [COL_W-1:0]  col_f_o
);
  logic              act_q, ap_q;
  logic [BA_W-1:0]   bank_q;
  logic [COL_W-1:0]  col_q;
  logic [PAIR_W-1:0] idx_q, lim_q;
  logic [COL_W-1:0]  mask, base, off;

  assign last_o = act_q && (idx_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      idx_q  <= '0;
      lim_q  <= '0;
    end else if (load_i) begin
      // a new launch overrides the running burst (truncate or chain)
      act_q  <= 1'b1;
      ap_q   <= cmd_i.ap;
      bank_q <= cmd_i.bank;
      col_q  <= cmd_i.col;
      idx_q  <= '0;
      lim_q  <= lim_i;
    end else if (last_o) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    mask    = COL_W'({lim_q, 1'b1});
    base    = col_q & ~mask;
    off     = col_q + COL_W'({idx_q, 1'b0});
    col_r_o = base | (off & mask);
    col_f_o = base | ((off + 1'b1) & mask);
  end

  assign act_o  = act_q;
  assign ap_o   = ap_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/ddr_rd_word_src.sv
module ddr_rd_word_src
  import ddr_rd_pkg::*;
#(
  parameter int unsigned NPORT = 2
) (
  input  logic [BA_W-1:0]              bank_i,
  input  logic [NPORT-1:0][COL_W-1:0]  col_i,
  output logic [NPORT-1:0][DQ_W-1:0]   word_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign word_o[p] = cell_word(bank_i, col_i[p]);
  end
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import ddr_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [BA_W-1:0]  rd_bank_i,
  input  logic [COL_W-1:0] rd_col_i,
  input  logic             rd_ap_i,
  input  logic             cas3_i,
  input  logic [1:0]       bl_sel_i,
  output logic [DQ_W-1:0]  dq_rise_o,
  output logic [DQ_W-1:0]  dq_fall_o,
  output logic             dq_oe_o,
  output logic [1:0]       dqs_o,
  output logic             dqs_oe_o,
  output logic             pre_req_o,
  output logic [BA_W-1:0]  pre_bank_o
);
  logic              cl3_q;
  logic [PAIR_W-1:0] lim_q;
  logic              pipe_busy, act, last, ap;
  logic [BA_W-1:0]   bank;
  logic [COL_W-1:0]  col_r, col_f;
  logic [1:0][COL_W-1:0] cols;
  logic [1:0][DQ_W-1:0]  words;
  rd_cmd_t           cmd_in, tap;
  logic              preamble;

  // configuration only moves while nothing is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl3_q <= 1'b0;
      lim_q <= '0;
    end else if (!pipe_busy && !act) begin
      cl3_q <= cas3_i;
      lim_q <= last_pair(bl_sel_i);
    end
  end

  assign cmd_in = '{vld: rd_i, bank: rd_bank_i, col: rd_col_i, ap: rd_ap_i};

  ddr_rd_cmd_pipe u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_in),
    .cl3_i  (cl3_q),
    .tap_o  (tap),
    .busy_o (pipe_busy)
  );

  ddr_rd_burst_eng u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tap.vld),
    .cmd_i   (tap),
    .lim_i   (lim_q),
    .act_o   (act),
    .last_o  (last),
    .ap_o    (ap),
    .bank_o  (bank),
    .col_r_o (col_r),
    .col_f_o (col_f)
  );

  assign cols = {col_f, col_r};

  ddr_rd_word_src #(.NPORT(2)) u_src (
    .bank_i (bank),
    .col_i  (cols),
    .word_o (words)
  );

  // launch cycle with no data under it is the preamble
  assign preamble = tap.vld && !act;

  assign dq_oe_o    = act;
  assign dq_rise_o  = act ? words[0] : '0;
  assign dq_fall_o  = act ? words[1] : '0;
  assign dqs_oe_o   = act | preamble;
  assign dqs_o      = act ? 2'b10 : 2'b00;
  assign pre_req_o  = last && ap;
  assign pre_bank_o = pre_req_o ? bank : '0;
endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk
  import ddr_rd_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dq_oe_o,
  input logic            dqs_oe_o,
  input logic [1:0]      dqs_o,
  input logic            pre_req_o,
  input logic [DQ_W-1:0] dq_rise_o,
  input logic [DQ_W-1:0] dq_fall_o
);
  // R5
  strobe_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_oe_o && dqs_o == 2'b10));

  // R5
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> (dqs_o == 2'b00 && dq_rise_o == '0 && dq_fall_o == '0));

  // R6
  preamble_then_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_o && !dq_oe_o) |=> dq_oe_o);

  // R6
  data_after_preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_oe_o));

  // R11
  precharge_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> dq_oe_o);
endmodule

bind ddr_rd_seq ddr_rd_seq_chk u_chk (.*);

// File: tb/ddr_rd_seq_bench.sv
module ddr_rd_seq_bench;
  import ddr_rd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HZN        = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rd_i = 1'b0;
  logic [BA_W-1:0]  rd_bank_i = '0;
  logic [COL_W-1:0] rd_col_i = '0;
  logic             rd_ap_i = 1'b0;
  logic             cas3_i = 1'b0;
  logic [1:0]       bl_sel_i = 2'b00;
  logic [DQ_W-1:0]  dq_rise_o, dq_fall_o;
  logic             dq_oe_o, dqs_oe_o, pre_req_o;
  logic [1:0]       dqs_o;
  logic [BA_W-1:0]  pre_bank_o;

  int nchk = 0;
  int nfail = 0;

  // expected per-cycle view of one scenario
  logic             e_oe [HZN];
  logic             e_soe[HZN];
  logic             e_st [HZN];
  logic             e_pre[HZN];
  logic [BA_W-1:0]  e_pb [HZN];
  logic [DQ_W-1:0]  e_r  [HZN];
  logic [DQ_W-1:0]  e_f  [HZN];
  logic             c_v  [HZN];
  logic [BA_W-1:0]  c_bk [HZN];
  logic [COL_W-1:0] c_col[HZN];
  logic             c_ap [HZN];
  logic             f_cl3[HZN];
  logic [1:0]       f_bl [HZN];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_rd_seq u_ddr_rd_seq (.*);

  function automatic logic [15:0] ref_word(input int b, input int k);
    logic [5:0] a;
    a = 6'(b * 16 + k);
    return {4'b0000, ~a, a};
  endfunction

  function automatic int ref_col(input int col, input int n, input int bl);
    return (col & ~(bl - 1)) | ((col + n) & (bl - 1));
  endfunction

  task automatic clear_plan(input logic cl3, input logic [1:0] bl);
    for (int c = 0; c < HZN; c++) begin
      e_oe[c] = 0; e_soe[c] = 0; e_st[c] = 0; e_pre[c] = 0; e_pb[c] = '0;
      e_r[c] = '0; e_f[c] = '0;
      c_v[c] = 0; c_bk[c] = '0; c_col[c] = '0; c_ap[c] = 0;
      f_cl3[c] = cl3; f_bl[c] = bl;
    end
  endtask

  // READ in cycle c; pairs = number of pairs expected to reach the bus
  task automatic sched(input int c, input int b, input int col, input bit ap,
                       input int cl, input int bl, input int pairs);
    c_v[c] = 1; c_bk[c] = BA_W'(b); c_col[c] = COL_W'(col); c_ap[c] = ap;
    for (int i = 0; i < pairs; i++) begin
      e_oe[c+cl+i] = 1;
      e_r[c+cl+i]  = ref_word(b, ref_col(col, 2*i, bl));
      e_f[c+cl+i]  = ref_word(b, ref_col(col, 2*i+1, bl));
      if (i == 0) e_st[c+cl] = 1;
      if (ap && pairs == bl/2 && i == pairs-1) begin
        e_pre[c+cl+i] = 1;
        e_pb[c+cl+i]  = BA_W'(b);
      end
    end
  endtask

  task automatic check_cycle(input int c, input string tag);
    logic [1:0] xdqs;
    bit bad;
    xdqs = e_oe[c] ? 2'b10 : 2'b00;
    bad = (dq_oe_o !== e_oe[c]) || (dqs_oe_o !== e_soe[c]) || (dqs_o !== xdqs) ||
          (dq_rise_o !== e_r[c]) || (dq_fall_o !== e_f[c]) || (pre_req_o !== e_pre[c]) ||
          (e_pre[c] && pre_bank_o !== e_pb[c]);
    nchk++;
    if (bad) begin
      nfail++;
      $display("FAIL %s cycle %0d: got oe=%b soe=%b dqs=%b r=%h f=%h pre=%b/%0d exp oe=%b soe=%b dqs=%b r=%h f=%h pre=%b/%0d",
               tag, c, dq_oe_o, dqs_oe_o, dqs_o, dq_rise_o, dq_fall_o, pre_req_o, pre_bank_o,
               e_oe[c], e_soe[c], xdqs, e_r[c], e_f[c], e_pre[c], e_pb[c]);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int c = 0; c < HZN; c++) e_soe[c] = e_oe[c];
    for (int c = 1; c < HZN; c++)
      if (e_st[c] && !e_oe[c-1]) e_soe[c-1] = 1;  // preamble
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      check_cycle(c, tag);
      rd_i = c_v[c]; rd_bank_i = c_bk[c]; rd_col_i = c_col[c]; rd_ap_i = c_ap[c];
      cas3_i = f_cl3[c]; bl_sel_i = f_bl[c];
    end
    rd_i = 0;
  endtask

  task automatic t_reset();
    clear_plan(0, 2'b00);
    run(4, "R1 idle after reset");
  endtask

  task automatic t_single();
    clear_plan(0, 2'b01);
    sched(1, 1, 5, 0, 2, 4, 2);
    run(10, "R2 R3 R4 R5 R6 R7 single CL2 BL4");
  endtask

  task automatic t_single_cl3();
    clear_plan(1, 2'b10);
    sched(1, 2, 13, 1, 3, 8, 4);
    run(12, "R2 R4 R11 single CL3 BL8 autoprecharge");
  endtask

  task automatic t_truncate();
    clear_plan(0, 2'b10);
    sched(1, 0, 0, 1, 2, 8, 2);
    sched(3, 3, 6, 1, 2, 8, 4);
    run(14, "R8 R11 truncated burst");
  endtask

  task automatic t_concat();
    clear_plan(1, 2'b01);
    sched(1, 1, 2, 1, 3, 4, 2);
    sched(3, 2, 9, 0, 3, 4, 2);
    run(12, "R9 R11 concatenated bursts");
  endtask

  task automatic t_stream();
    clear_plan(0, 2'b00);
    sched(1, 0, 3, 0, 2, 2, 1);
    sched(2, 1, 8, 1, 2, 2, 1);
    sched(3, 2, 15, 0, 2, 2, 1);
    sched(4, 3, 0, 1, 2, 2, 1);
    run(10, "R9 R11 BL2 every clock");
  endtask

  task automatic t_gap();
    clear_plan(0, 2'b01);
    sched(1, 0, 1, 0, 2, 4, 2);
    sched(4, 1, 3, 0, 2, 4, 2);
    sched(8, 3, 14, 1, 2, 4, 2);
    run(16, "R10 R6 R7 non-consecutive reads");
  endtask

  task automatic t_cfg();
    clear_plan(0, 2'b01);
    for (int c = 2; c < HZN; c++) begin
      f_cl3[c] = 1; f_bl[c] = 2'b10;
    end
    sched(1, 2, 0, 0, 2, 4, 2);
    sched(3, 1, 4, 0, 2, 4, 2);
    sched(9, 0, 7, 1, 3, 8, 4);
    run(20, "R12 config held while busy");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    nchk++;
    if (dq_oe_o !== 0 || dqs_oe_o !== 0 || pre_req_o !== 0 || dqs_o !== 2'b00 ||
        dq_rise_o !== '0 || dq_fall_o !== '0) begin
      nfail++;
      $display("FAIL R1 in reset: got oe=%b soe=%b pre=%b dqs=%b exp all zero",
               dq_oe_o, dqs_oe_o, pre_req_o, dqs_o);
    end
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_single_cl3();
    t_truncate();
    t_concat();
    t_stream();
    t_gap();
    t_cfg();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule